// File: doc/BRIEF.md
# Modem Handshake Control and Status with Loopback

This block is the modem-line section of one asynchronous serial port. A host writes a small control register whose bits drive four active-low handshake outputs:

- terminal ready
- request to send
- a spare user output
- an interrupt-enable output

The host reads a status register. Its upper half shows the current asserted state of four active-low handshake inputs: clear to send, set ready, ring, and carrier. Its lower half holds sticky change flags. Any set change flag raises a modem-status interrupt request. The same interrupt-enable bit also gates the port's combined interrupt line.

The external handshake inputs pass through a synchroniser before any edge is detected. A change that lands in the same cycle as a status read is kept for the next read.

A loopback bit makes the block turn itself around for self-test:

- All four outputs go inactive (high).
- A loopback select is raised for the serial data path.
- The control bits feed the status inputs directly:
  - terminal ready appears as set ready
  - request to send appears as clear to send
  - the spare output appears as ring
  - the interrupt-enable output appears as carrier

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the control register reads 0x00. A write with `addr_i`=0 loads bits 4..0 (bit 0 terminal ready, bit 1 request to send, bit 2 spare output, bit 3 interrupt enable, bit 4 loopback). Bits 7..5 always read 0.
- R2: Outside loopback, a control bit of 1 drives its output pin low, and a 0 drives it high.
- R3: A status read (`addr_i`=1) returns the asserted state (the complement of the pin) of carrier in bit 7, ring in bit 6, set ready in bit 5 and clear to send in bit 4. These bits reflect a pin change two clock edges after the pin moves.
- R4: Status bits 3 (carrier), 1 (set ready) and 0 (clear to send) set when the matching asserted state changes in either direction.
- R5: Status bit 2 sets only when the ring pin goes from low to high. The pin going from high to low sets nothing.
- R6: A status read clears bits 3..0 on the clock edge that ends the read.
- R7: A change detected in the same cycle as a status read leaves its flag set after the read.
- R8: `msr_irq_o` is 1 exactly while any of status bits 3..0 is 1.
- R9: `irq_o` equals `port_irq_i` while control bit 3 is 1, and is 0 otherwise, in every mode.
- R10: With control bit 4 set:
  - all four output pins read 1 and `loop_sel_o` is 1;
  - status bits 4, 5, 6 and 7 follow control bits 1, 0, 2 and 3, with their change flags working as in R4 to R5;
  - the external input pins have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Register select: 0 control, 1 status |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; a status read clears the change flags |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Set-ready pin, active low |
| ri_n_i | input | 1 | Ring pin, active low |
| dcd_n_i | input | 1 | Carrier pin, active low |
| dtr_n_o | output | 1 | Terminal-ready pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| out1_n_o | output | 1 | Spare user output, active low |
| out2_n_o | output | 1 | Interrupt-enable output, active low |
| loop_sel_o | output | 1 | Loopback select for the serial data path |
| port_irq_i | input | 1 | Combined interrupt request of the port |
| irq_o | output | 1 | Port interrupt gated by the enable bit |
| msr_irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with its default two-stage synchroniser. This fixes the pin-to-flag latency at a known count of edges. The bench can therefore place a status read in exactly the cycle a change is being detected, which brings the read-versus-set collision within reach. Both ring directions are driven, and loopback is entered with every route changing at once. Each route is then dropped one by one while the external pins toggle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned CTRL_W   = 5;
    localparam int unsigned LINE_CNT = 4;

    localparam int unsigned IDX_CTS = 0;
    localparam int unsigned IDX_DSR = 1;
    localparam int unsigned IDX_RI  = 2;
    localparam int unsigned IDX_DCD = 3;

    localparam int unsigned BIT_DTR  = 0;
    localparam int unsigned BIT_RTS  = 1;
    localparam int unsigned BIT_OUT1 = 2;
    localparam int unsigned BIT_OUT2 = 3;
    localparam int unsigned BIT_LOOP = 4;

    typedef logic [LINE_CNT-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t prev;
        line_vec_t delta;
    } chg_state_t;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } ctl_state_t;
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/mcs_loop_mux.sv
module mcs_loop_mux
    import mcs_pkg::*;
(
    input  line_vec_t         ext_asserted_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output line_vec_t         cur_o,
    output logic              dtr_n_o,
    output logic              rts_n_o,
    output logic              out1_n_o,
    output logic              out2_n_o
);
    logic loop;
    line_vec_t looped;

    assign loop = ctrl_i[BIT_LOOP];

    always_comb begin
        looped          = '0;
        looped[IDX_DSR] = ctrl_i[BIT_DTR];
        looped[IDX_CTS] = ctrl_i[BIT_RTS];
        looped[IDX_RI]  = ctrl_i[BIT_OUT1];
        looped[IDX_DCD] = ctrl_i[BIT_OUT2];
        cur_o    = loop ? looped : ext_asserted_i;
        dtr_n_o  = !(ctrl_i[BIT_DTR]  && !loop);
        rts_n_o  = !(ctrl_i[BIT_RTS]  && !loop);
        out1_n_o = !(ctrl_i[BIT_OUT1] && !loop);
        out2_n_o = !(ctrl_i[BIT_OUT2] && !loop);
    end
endmodule

// File: rtl/mcs_delta.sv
module mcs_delta
    import mcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t cur_i,
    input  logic      rd_clr_i,
    output line_vec_t delta_o
);
    chg_state_t st_d, st_q;
    line_vec_t  hit;

    always_comb begin
        hit          = cur_i ^ st_q.prev;
        hit[IDX_RI]  = st_q.prev[IDX_RI] && !cur_i[IDX_RI];
        st_d.prev    = cur_i;
        st_d.delta   = (rd_clr_i ? '0 : st_q.delta) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign delta_o = st_q.delta;

    assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && (cur_i == st_q.prev)) |=> (delta_o == '0));

    assert_keep_on_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && (cur_i[IDX_CTS] != st_q.prev[IDX_CTS])) |=> delta_o[IDX_CTS]);

    assert_ring_trailing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.prev[IDX_RI] || cur_i[IDX_RI]) && (rd_clr_i || !delta_o[IDX_RI])
        |=> !delta_o[IDX_RI]);
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
    import mcs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic             cts_n_i,
    input  logic             dsr_n_i,
    input  logic             ri_n_i,
    input  logic             dcd_n_i,
    output logic             dtr_n_o,
    output logic             rts_n_o,
    output logic             out1_n_o,
    output logic             out2_n_o,
    output logic             loop_sel_o,
    input  logic             port_irq_i,
    output logic             irq_o,
    output logic             msr_irq_o
);
    localparam int unsigned PAD_W = REG_W - CTRL_W;

    ctl_state_t ctl_d, ctl_q;
    line_vec_t  pin_raw, pin_sync, cur, delta;
    logic       unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[REG_W-1:CTRL_W];

    always_comb begin
        pin_raw          = '1;
        pin_raw[IDX_CTS] = cts_n_i;
        pin_raw[IDX_DSR] = dsr_n_i;
        pin_raw[IDX_RI]  = ri_n_i;
        pin_raw[IDX_DCD] = dcd_n_i;
    end

    mcs_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINE_CNT), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_raw), .sync_o(pin_sync)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en_i && !addr_i) begin
            ctl_d.ctrl = wdata_i[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    mcs_loop_mux u_mux (
        .ext_asserted_i(~pin_sync), .ctrl_i(ctl_q.ctrl), .cur_o(cur),
        .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .out1_n_o(out1_n_o), .out2_n_o(out2_n_o)
    );

    mcs_delta u_delta (
        .clk(clk), .rst_n(rst_n), .cur_i(cur),
        .rd_clr_i(rd_en_i && addr_i), .delta_o(delta)
    );

    always_comb begin
        if (addr_i) begin
            rdata_o = {cur, delta};
        end else begin
            rdata_o = {{PAD_W{1'b0}}, ctl_q.ctrl};
        end
    end

    assign loop_sel_o = ctl_q.ctrl[BIT_LOOP];
    assign irq_o      = port_irq_i && ctl_q.ctrl[BIT_OUT2];
    assign msr_irq_o  = |delta;

    assert_pins_idle_loop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        loop_sel_o |-> (dtr_n_o && rts_n_o && out1_n_o && out2_n_o));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out2_n_o && !loop_sel_o |-> !irq_o);

    assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(ctl_q.ctrl));
endmodule

// File: tb/modem_ctl_stat_tb.sv
`timescale 1ns/1ps
module modem_ctl_stat_tb;
    logic clk = 0, rst_n = 0;
    logic addr = 0, wr_en = 0, rd_en = 0;
    logic [7:0] wdata = 0, rdata;
    logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
    logic dtr_n, rts_n, out1_n, out2_n, loop_sel, port_irq = 0, irq, msr_irq;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    event rd_ev;

    always #2 clk = ~clk;

    modem_ctl_stat u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .wdata_i(wdata), .rdata_o(rdata), .cts_n_i(cts_n), .dsr_n_i(dsr_n),
        .ri_n_i(ri_n), .dcd_n_i(dcd_n), .dtr_n_o(dtr_n), .rts_n_o(rts_n),
        .out1_n_o(out1_n), .out2_n_o(out2_n), .loop_sel_o(loop_sel),
        .port_irq_i(port_irq), .irq_o(irq), .msr_irq_o(msr_irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected read value and compares
    always @(rd_ev) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
    end

    task automatic wr(input logic [7:0] v);
        addr = 0; wdata = v; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
        addr = sel; rd_en = 1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        #1 -> rd_ev;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got 0x00 expected 0x01");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(2);
        rst_n = 1;
        idle(2);
        // R1 reset state
        rd(0, 8'h00, "R1 ctrl reset");
        rd(1, 8'h00, "R3 status reset");
        check("R2 pins reset", {4'h0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
        check("R8 irq reset", {7'h0, msr_irq}, 8'h00);
        // R1 reserved bits / R2 polarity
        wr(8'hEF);
        rd(0, 8'h0F, "R1 reserved bits zero");
        check("R2 pins all active", {4'h0, dtr_n, rts_n, out1_n, out2_n}, 8'h00);
        wr(8'h05);
        check("R2 pins mixed", {4'h0, dtr_n, rts_n, out1_n, out2_n}, 8'h05);
        // R3/R4 clear to send asserted
        cts_n = 0; idle(4);
        check("R8 msr irq set", {7'h0, msr_irq}, 8'h01);
        rd(1, 8'h11, "R4 cts delta");
        rd(1, 8'h10, "R6 cleared");
        check("R8 msr irq clear", {7'h0, msr_irq}, 8'h00);
        // R5 ring both directions
        ri_n = 0; idle(4);
        rd(1, 8'h50, "R5 ring falling pin no flag");
        ri_n = 1; idle(4);
        rd(1, 8'h14, "R5 ring trailing edge");
        rd(1, 8'h10, "R6 ring flag cleared");
        // R4 carrier and set ready
        dcd_n = 0; dsr_n = 0; idle(4);
        rd(1, 8'hBA, "R4 dcd dsr deltas");
        rd(1, 8'hB0, "R6 cleared again");
        // R7 collision: read in the cycle the change is detected
        cts_n = 1;
        idle(2);
        rd(1, 8'hA0, "R7 read during detect");
        rd(1, 8'hA1, "R7 flag kept");
        dcd_n = 1; dsr_n = 1; idle(4);
        rd(1, 8'h0A, "R4 deassert deltas");
        rd(1, 8'h00, "R6 all clear");
        // R9 interrupt gating
        port_irq = 1; idle(1);
        check("R9 gated off", {7'h0, irq}, 8'h00);
        wr(8'h08);
        check("R9 gated on", {7'h0, irq}, 8'h01);
        port_irq = 0; idle(1);
        // R10 loopback
        wr(8'h1F); idle(2);
        check("R10 pins idle", {3'h0, loop_sel, dtr_n, rts_n, out1_n, out2_n}, 8'h1F);
        rd(1, 8'hFB, "R10 loop routes on");
        rd(1, 8'hF0, "R10 loop cleared");
        wr(8'h1E); idle(2);
        rd(1, 8'hD2, "R10 dtr to dsr");
        rd(1, 8'hD0, "R10 cleared");
        wr(8'h1A); idle(2);
        rd(1, 8'h94, "R10 out1 to ring trailing");
        cts_n = 0; ri_n = 0; dcd_n = 0; idle(4);
        ri_n = 1; idle(4);
        rd(1, 8'h90, "R10 external pins ignored");
        port_irq = 1; idle(1);
        check("R9 gate in loopback", {7'h0, irq}, 8'h01);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule